// File: doc/BRIEF.md
# Translation Buffer with Victim Array

This block caches virtual-to-physical page translations for a small number of MMU modes. Each mode owns a direct-mapped primary array and a small fully associative victim array. A lookup carries a virtual page number and a mode and is answered with a hit flag, a physical page number, read and write permission bits and a dirty bit. When the primary slot does not match, the victim array is searched. When that also misses, the block raises a refill request to an external page-table walker and waits for the translation to come back.

A refill never throws away the translation it replaces. The displaced primary entry is copied into the victim slot named by a round-robin pointer. On a victim hit, the victim entry and the indexed primary entry trade places, so the entry used most recently sits in the primary array. Software-style maintenance commands are also accepted: flush everything, flush one page in one mode, and mark one page dirty in every mode.

Top module: `vtlb_xlate`

## Requirements
- R1: The primary slot is picked by the low log2(PRI_DEPTH) bits of the virtual page number (bits [3:0] by default). A valid entry whose stored page number equals the request produces rsp_valid with rsp_hit=1, the stored PPN, permissions and dirty bit, one cycle after the lookup is accepted.
- R2: On a primary miss the victim array of the same mode is searched. A match answers with rsp_hit=1 two cycles after acceptance, and the victim entry trades places with the indexed primary entry, so the next lookup of that page hits in the primary array.
- R3: When both arrays miss, fill_req rises and fill_vpn/fill_mode hold the request until a refill is taken. The refill is answered with rsp_valid, rsp_hit=0, the refill PPN and permissions, and fill_req falls.
- R4: A refill copies the displaced primary entry into the victim slot at a pointer that advances by one on every refill and wraps after VIC_DEPTH refills, overwriting the oldest victim entry.
- R5: A flush-all command invalidates every primary and victim entry in every mode and returns the victim pointer to slot 0.
- R6: A page flush invalidates the matching primary entry and every matching victim entry of the named mode only. Entries of other modes stay valid.
- R7: Each mode has its own arrays. The same page may hold different translations in different modes.
- R8: A set-dirty command sets the dirty bit of every valid entry for that page, in the primary and victim arrays of every mode. A refilled entry starts with its dirty bit clear.
- R9: A cycle carrying any command (flush_all, flush_page or set_dirty) does no lookup work. lk_ready is low, no response is produced, and a refill offered in that cycle is ignored, with fill_req still high afterwards.
- R10: lk_ready is low while a lookup is in its victim search or waiting for a refill.
- R11: After reset, lk_ready is high, fill_req and rsp_valid are low, and every entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request present |
| lk_ready | output | 1 | Lookup can be accepted this cycle |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_mode | input | 1 | MMU mode of the lookup |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | 1 if served from the primary or victim array, 0 if from refill |
| rsp_ppn | output | 20 | Physical page number |
| rsp_rd | output | 1 | Read permission |
| rsp_wr | output | 1 | Write permission |
| rsp_dirty | output | 1 | Dirty bit |
| fill_req | output | 1 | Refill wanted for the pending lookup |
| fill_vpn | output | 20 | Page needing a refill |
| fill_mode | output | 1 | Mode needing a refill |
| fill_valid | input | 1 | Refill data present |
| fill_ppn | input | 20 | Refill physical page number |
| fill_rd | input | 1 | Refill read permission |
| fill_wr | input | 1 | Refill write permission |
| flush_all | input | 1 | Invalidate everything |
| flush_page | input | 1 | Invalidate one page in one mode |
| set_dirty | input | 1 | Mark one page dirty in all modes |
| cmd_vpn | input | 20 | Page for flush_page / set_dirty |
| cmd_mode | input | 1 | Mode for flush_page |

## Verification
The victim-uniqueness check assumes a page is never present twice in one mode's victim array. That holds only if refill data arrives solely against an outstanding fill_req, because the block refills a page only after both arrays have missed. The pointer and hold checks also assume mode values below MODES. The stimulus drives fill_valid only after it has seen fill_req, uses modes 0 and 1, raises one command flag at a time, and waits for each response before it issues the next lookup.

// File: rtl/vtlb_pkg.sv
`timescale 1ns/1ps
package vtlb_pkg;

    localparam int VPN_W = 20;
    localparam int PPN_W = 20;

    typedef struct packed {
        logic             valid;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
        logic             rd;
        logic             wr;
        logic             dirty;
    } tlb_entry_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_VSRCH = 2'd1,
        ST_FILL  = 2'd2
    } ctl_state_t;

    function automatic logic entry_match(input tlb_entry_t e, input logic [VPN_W-1:0] v);
        return e.valid && (e.vpn == v);
    endfunction

    function automatic int unsigned sel_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/vtlb_primary.sv
`timescale 1ns/1ps
module vtlb_primary
    import vtlb_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int MODES = 2,
    localparam int IDX_W  = sel_w(DEPTH),
    localparam int MODE_W = sel_w(MODES)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] rd_mode,
    input  logic [VPN_W-1:0]  rd_vpn,
    output tlb_entry_t        rd_entry,
    input  logic              wr_en,
    input  tlb_entry_t        wr_entry,
    input  logic              flush_all,
    input  logic              pflush_en,
    input  logic              dirty_en,
    input  logic [MODE_W-1:0] cmd_mode,
    input  logic [VPN_W-1:0]  cmd_vpn
);

    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] cmd_idx;
    tlb_entry_t       mode_rd [MODES];

    assign rd_idx  = rd_vpn[IDX_W-1:0];
    assign cmd_idx = cmd_vpn[IDX_W-1:0];

    generate
        for (genvar g = 0; g < MODES; g++) begin : g_mode
            tlb_entry_t slot [DEPTH];

            always_ff @(posedge clk) begin
                if (rst || flush_all) begin
                    for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
                end else if (pflush_en) begin
                    if (cmd_mode == MODE_W'(g) && entry_match(slot[cmd_idx], cmd_vpn))
                        slot[cmd_idx].valid <= 1'b0;
                end else if (dirty_en) begin
                    if (entry_match(slot[cmd_idx], cmd_vpn))
                        slot[cmd_idx].dirty <= 1'b1;
                end else if (wr_en && rd_mode == MODE_W'(g)) begin
                    slot[rd_idx] <= wr_entry;
                end
            end

            assign mode_rd[g] = slot[rd_idx];
        end
    endgenerate

    assign rd_entry = mode_rd[rd_mode];

    AST_PRI_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (rst)
        flush_all |=> !rd_entry.valid)
        else $error("primary entry valid after flush"); // R5

endmodule

// File: rtl/vtlb_victim.sv
`timescale 1ns/1ps
module vtlb_victim
    import vtlb_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int MODES = 2,
    localparam int PTR_W  = sel_w(DEPTH),
    localparam int MODE_W = sel_w(MODES)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] srch_mode,
    input  logic [VPN_W-1:0]  srch_vpn,
    output logic              srch_hit,
    output logic [PTR_W-1:0]  srch_slot,
    output tlb_entry_t        srch_entry,
    input  logic              swp_en,
    input  tlb_entry_t        swp_entry,
    input  logic              ins_en,
    input  tlb_entry_t        ins_entry,
    input  logic              flush_all,
    input  logic              pflush_en,
    input  logic              dirty_en,
    input  logic [MODE_W-1:0] cmd_mode,
    input  logic [VPN_W-1:0]  cmd_vpn
);

    logic [PTR_W-1:0] ptr;
    logic [DEPTH-1:0] hit_vec_m [MODES];
    logic [DEPTH-1:0] hit_vec;
    tlb_entry_t       mode_ent  [MODES][DEPTH];

    generate
        for (genvar g = 0; g < MODES; g++) begin : g_mode
            tlb_entry_t       slot [DEPTH];
            logic [DEPTH-1:0] hv;

            always_ff @(posedge clk) begin
                if (rst || flush_all) begin
                    for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
                end else if (pflush_en) begin
                    if (cmd_mode == MODE_W'(g)) begin
                        for (int i = 0; i < DEPTH; i++)
                            if (entry_match(slot[i], cmd_vpn)) slot[i].valid <= 1'b0;
                    end
                end else if (dirty_en) begin
                    for (int i = 0; i < DEPTH; i++)
                        if (entry_match(slot[i], cmd_vpn)) slot[i].dirty <= 1'b1;
                end else if (srch_mode == MODE_W'(g)) begin
                    if (swp_en) slot[srch_slot] <= swp_entry;
                    else if (ins_en) slot[ptr] <= ins_entry;
                end
            end

            always_comb begin
                for (int i = 0; i < DEPTH; i++) hv[i] = entry_match(slot[i], srch_vpn);
            end

            assign hit_vec_m[g] = hv;

            for (genvar i = 0; i < DEPTH; i++) begin : g_out
                assign mode_ent[g][i] = slot[i];
            end
        end
    endgenerate

    assign hit_vec  = hit_vec_m[srch_mode];
    assign srch_hit = |hit_vec;

    always_comb begin
        srch_slot = '0;
        for (int i = DEPTH - 1; i >= 0; i--)
            if (hit_vec[i]) srch_slot = PTR_W'(i);
    end

    assign srch_entry = mode_ent[srch_mode][srch_slot];

    always_ff @(posedge clk) begin
        if (rst || flush_all)
            ptr <= '0;
        else if (ins_en)
            ptr <= (ptr == PTR_W'(DEPTH - 1)) ? '0 : ptr + PTR_W'(1);
    end

    AST_VIC_UNIQUE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec))
        else $error("page present twice in victim array"); // R2

    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (ins_en && !flush_all) |=>
            ptr == (($past(ptr) == PTR_W'(DEPTH - 1)) ? '0 : $past(ptr) + PTR_W'(1)))
        else $error("victim pointer did not step"); // R4

    AST_PTR_FLUSH: assert property (@(posedge clk) disable iff (rst)
        flush_all |=> ptr == '0)
        else $error("victim pointer not cleared by flush"); // R5

endmodule

// File: rtl/vtlb_xlate.sv
`timescale 1ns/1ps
module vtlb_xlate
    import vtlb_pkg::*;
#(
    parameter int PRI_DEPTH = 16,
    parameter int VIC_DEPTH = 8,
    parameter int MODES     = 2,
    localparam int MODE_W   = sel_w(MODES),
    localparam int SLOT_W   = sel_w(VIC_DEPTH)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    output logic              lk_ready,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [MODE_W-1:0] lk_mode,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PPN_W-1:0]  rsp_ppn,
    output logic              rsp_rd,
    output logic              rsp_wr,
    output logic              rsp_dirty,
    output logic              fill_req,
    output logic [VPN_W-1:0]  fill_vpn,
    output logic [MODE_W-1:0] fill_mode,
    input  logic              fill_valid,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic              fill_rd,
    input  logic              fill_wr,
    input  logic              flush_all,
    input  logic              flush_page,
    input  logic              set_dirty,
    input  logic [VPN_W-1:0]  cmd_vpn,
    input  logic [MODE_W-1:0] cmd_mode
);

    ctl_state_t        state;
    logic [VPN_W-1:0]  req_vpn;
    logic [MODE_W-1:0] req_mode;

    logic              cmd_busy;
    logic              accept;
    logic              step_vs;
    logic              step_fill;
    logic [VPN_W-1:0]  addr_vpn;
    logic [MODE_W-1:0] addr_mode;

    tlb_entry_t        pri_rd;
    logic              pri_hit;
    logic              pri_wr_en;
    tlb_entry_t        pri_wr_ent;

    logic              vic_hit;
    logic [SLOT_W-1:0] vic_slot;
    tlb_entry_t        vic_ent;
    tlb_entry_t        new_ent;

    assign cmd_busy  = flush_all | flush_page | set_dirty;
    assign lk_ready  = (state == ST_IDLE) && !cmd_busy;
    assign accept    = lk_valid && lk_ready;
    assign step_vs   = (state == ST_VSRCH) && !cmd_busy;
    assign step_fill = (state == ST_FILL) && !cmd_busy && fill_valid;

    assign addr_vpn  = (state == ST_IDLE) ? lk_vpn  : req_vpn;
    assign addr_mode = (state == ST_IDLE) ? lk_mode : req_mode;
    assign pri_hit   = entry_match(pri_rd, addr_vpn);

    always_comb begin
        new_ent       = '0;
        new_ent.valid = 1'b1;
        new_ent.vpn   = req_vpn;
        new_ent.ppn   = fill_ppn;
        new_ent.rd    = fill_rd;
        new_ent.wr    = fill_wr;
        new_ent.dirty = 1'b0;
    end

    assign pri_wr_en  = (step_vs && vic_hit) || step_fill;
    assign pri_wr_ent = step_fill ? new_ent : vic_ent;

    assign fill_vpn  = req_vpn;
    assign fill_mode = req_mode;

    vtlb_primary #(.DEPTH(PRI_DEPTH), .MODES(MODES)) u_primary (
        .clk       (clk),
        .rst       (rst),
        .rd_mode   (addr_mode),
        .rd_vpn    (addr_vpn),
        .rd_entry  (pri_rd),
        .wr_en     (pri_wr_en),
        .wr_entry  (pri_wr_ent),
        .flush_all (flush_all),
        .pflush_en (flush_page),
        .dirty_en  (set_dirty),
        .cmd_mode  (cmd_mode),
        .cmd_vpn   (cmd_vpn)
    );

    vtlb_victim #(.DEPTH(VIC_DEPTH), .MODES(MODES)) u_victim (
        .clk        (clk),
        .rst        (rst),
        .srch_mode  (req_mode),
        .srch_vpn   (req_vpn),
        .srch_hit   (vic_hit),
        .srch_slot  (vic_slot),
        .srch_entry (vic_ent),
        .swp_en     (step_vs && vic_hit),
        .swp_entry  (pri_rd),
        .ins_en     (step_fill),
        .ins_entry  (pri_rd),
        .flush_all  (flush_all),
        .pflush_en  (flush_page),
        .dirty_en   (set_dirty),
        .cmd_mode   (cmd_mode),
        .cmd_vpn    (cmd_vpn)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            req_vpn   <= '0;
            req_mode  <= '0;
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_ppn   <= '0;
            rsp_rd    <= 1'b0;
            rsp_wr    <= 1'b0;
            rsp_dirty <= 1'b0;
            fill_req  <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        req_vpn  <= lk_vpn;
                        req_mode <= lk_mode;
                        if (pri_hit) begin
                            rsp_valid <= 1'b1;
                            rsp_hit   <= 1'b1;
                            rsp_ppn   <= pri_rd.ppn;
                            rsp_rd    <= pri_rd.rd;
                            rsp_wr    <= pri_rd.wr;
                            rsp_dirty <= pri_rd.dirty;
                        end else begin
                            state <= ST_VSRCH;
                        end
                    end
                end
                ST_VSRCH: begin
                    if (step_vs) begin
                        if (vic_hit) begin
                            rsp_valid <= 1'b1;
                            rsp_hit   <= 1'b1;
                            rsp_ppn   <= vic_ent.ppn;
                            rsp_rd    <= vic_ent.rd;
                            rsp_wr    <= vic_ent.wr;
                            rsp_dirty <= vic_ent.dirty;
                            state     <= ST_IDLE;
                        end else begin
                            fill_req <= 1'b1;
                            state    <= ST_FILL;
                        end
                    end
                end
                ST_FILL: begin
                    if (step_fill) begin
                        rsp_valid <= 1'b1;
                        rsp_hit   <= 1'b0;
                        rsp_ppn   <= fill_ppn;
                        rsp_rd    <= fill_rd;
                        rsp_wr    <= fill_wr;
                        rsp_dirty <= 1'b0;
                        fill_req  <= 1'b0;
                        state     <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_FILL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (fill_req && !(fill_valid && !cmd_busy)) |=>
            (fill_req && $stable(fill_vpn) && $stable(fill_mode)))
        else $error("refill request dropped or changed"); // R3

    AST_FILL_DONE: assert property (@(posedge clk) disable iff (rst)
        (fill_req && fill_valid && !cmd_busy) |=> (rsp_valid && !rsp_hit && !fill_req))
        else $error("refill not answered"); // R3

    AST_CMD_NO_RSP: assert property (@(posedge clk) disable iff (rst)
        cmd_busy |=> !rsp_valid)
        else $error("response produced in a command cycle"); // R9

    AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (rst)
        fill_req |-> !lk_ready)
        else $error("lookup accepted while refill pending"); // R10

endmodule

// File: tb/tb_vtlb_xlate.sv
`timescale 1ns/1ps
module tb_vtlb_xlate;
    import vtlb_pkg::*;

    localparam int K_PRI  = 0;
    localparam int K_VIC  = 1;
    localparam int K_FILL = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             lk_valid = 1'b0;
    logic             lk_ready;
    logic [VPN_W-1:0] lk_vpn = '0;
    logic             lk_mode = 1'b0;
    logic             rsp_valid, rsp_hit, rsp_rd, rsp_wr, rsp_dirty;
    logic [PPN_W-1:0] rsp_ppn;
    logic             fill_req;
    logic [VPN_W-1:0] fill_vpn;
    logic             fill_mode;
    logic             fill_valid = 1'b0;
    logic [PPN_W-1:0] fill_ppn = '0;
    logic             fill_rd = 1'b0, fill_wr = 1'b0;
    logic             flush_all = 1'b0, flush_page = 1'b0, set_dirty = 1'b0;
    logic [VPN_W-1:0] cmd_vpn = '0;
    logic             cmd_mode = 1'b0;

    always #2.5 clk = ~clk;

    vtlb_xlate dut (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_vpn(lk_vpn), .lk_mode(lk_mode),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn),
        .rsp_rd(rsp_rd), .rsp_wr(rsp_wr), .rsp_dirty(rsp_dirty),
        .fill_req(fill_req), .fill_vpn(fill_vpn), .fill_mode(fill_mode),
        .fill_valid(fill_valid), .fill_ppn(fill_ppn), .fill_rd(fill_rd), .fill_wr(fill_wr),
        .flush_all(flush_all), .flush_page(flush_page), .set_dirty(set_dirty),
        .cmd_vpn(cmd_vpn), .cmd_mode(cmd_mode)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        bit               hit;
        logic [PPN_W-1:0] ppn;
        bit               rd;
        bit               wr;
        bit               dirty;
        int               start;
        int               lat;
        string            req;
    } exp_t;

    exp_t expq[$];
    exp_t mon_e;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: compares each response with the oldest expected item
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (expq.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R3 unexpected response: act=1 exp=0");
            end else begin
                mon_e = expq.pop_front();
                chk(mon_e.req, "hit",   rsp_hit,   mon_e.hit);
                chk(mon_e.req, "ppn",   rsp_ppn,   mon_e.ppn);
                chk(mon_e.req, "rd",    rsp_rd,    mon_e.rd);
                chk(mon_e.req, "wr",    rsp_wr,    mon_e.wr);
                chk(mon_e.req, "dirty", rsp_dirty, mon_e.dirty);
                if (mon_e.lat != 0)
                    chk(mon_e.req, "latency", cyc - mon_e.start, mon_e.lat);
            end
        end
    end

    // Driver: issues a lookup, pushes its expected result, serves a refill
    task automatic lookup(input logic [VPN_W-1:0] vpn, input logic mode, input int kind,
                          input logic [PPN_W-1:0] ppn, input bit rd, input bit wr,
                          input bit dirty, input string req, input bit blk = 0);
        exp_t e;
        @(negedge clk);
        while (!lk_ready) @(negedge clk);
        e.hit   = (kind != K_FILL);
        e.ppn   = ppn;
        e.rd    = rd;
        e.wr    = wr;
        e.dirty = dirty;
        e.start = cyc;
        e.lat   = (kind == K_PRI) ? 1 : (kind == K_VIC) ? 2 : 0;
        e.req   = req;
        expq.push_back(e);
        lk_valid = 1'b1;
        lk_vpn   = vpn;
        lk_mode  = mode;
        @(negedge clk);
        lk_valid = 1'b0;
        if (kind == K_FILL) begin
            while (!fill_req) @(negedge clk);
            chk("R3", "fill_vpn", fill_vpn, vpn);
            chk("R3", "fill_mode", fill_mode, mode);
            chk("R10", "lk_ready while refill pending", lk_ready, 0);
            fill_valid = 1'b1;
            fill_ppn   = ppn;
            fill_rd    = rd;
            fill_wr    = wr;
            if (blk) begin
                flush_page = 1'b1;
                cmd_vpn    = 20'h00999;
                cmd_mode   = 1'b0;
                @(negedge clk);
                chk("R9", "fill_req after refill in command cycle", fill_req, 1);
                chk("R9", "rsp_valid after command cycle", rsp_valid, 0);
                flush_page = 1'b0;
            end
            @(negedge clk);
            fill_valid = 1'b0;
        end
        while (expq.size() != 0) @(negedge clk);
    endtask

    task automatic command(input bit fa, input bit fp, input bit sd,
                           input logic [VPN_W-1:0] vpn, input logic mode);
        @(negedge clk);
        flush_all  = fa;
        flush_page = fp;
        set_dirty  = sd;
        cmd_vpn    = vpn;
        cmd_mode   = mode;
        #1;
        chk("R9", "lk_ready in command cycle", lk_ready, 0);
        @(negedge clk);
        flush_all  = 1'b0;
        flush_page = 1'b0;
        set_dirty  = 1'b0;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11", "lk_ready after reset", lk_ready, 1);
        chk("R11", "fill_req after reset", fill_req, 0);
        chk("R11", "rsp_valid after reset", rsp_valid, 0);

        // Slot 0 of mode 0: 0x00010 and 0x00020 collide
        lookup(20'h00010, 0, K_FILL, 20'h11110, 1, 1, 0, "R11");
        lookup(20'h00010, 0, K_PRI,  20'h11110, 1, 1, 0, "R1");
        lookup(20'h00020, 0, K_FILL, 20'h22220, 1, 0, 0, "R4");
        lookup(20'h00010, 0, K_VIC,  20'h11110, 1, 1, 0, "R2");
        lookup(20'h00010, 0, K_PRI,  20'h11110, 1, 1, 0, "R2");
        lookup(20'h00020, 0, K_VIC,  20'h22220, 1, 0, 0, "R2");
        // Per-mode arrays
        lookup(20'h00020, 1, K_FILL, 20'h33330, 1, 0, 0, "R7");
        lookup(20'h00020, 0, K_PRI,  20'h22220, 1, 0, 0, "R7");
        // Dirty marking in victim and primary arrays
        command(0, 0, 1, 20'h00010, 0);
        lookup(20'h00010, 0, K_VIC,  20'h11110, 1, 1, 1, "R8");
        command(0, 0, 1, 20'h00020, 0);
        lookup(20'h00020, 1, K_PRI,  20'h33330, 1, 0, 1, "R8");
        // Page flush of a primary entry, then of a victim entry
        command(0, 1, 0, 20'h00010, 0);
        lookup(20'h00010, 0, K_FILL, 20'h44440, 0, 1, 0, "R6");
        command(0, 1, 0, 20'h00020, 0);
        lookup(20'h00020, 1, K_PRI,  20'h33330, 1, 0, 1, "R6");
        lookup(20'h00020, 0, K_FILL, 20'h55550, 1, 1, 0, "R6");
        lookup(20'h00010, 0, K_VIC,  20'h44440, 0, 1, 0, "R8");
        // Round-robin wrap: eight refills on slot 1 push 0x00020 out
        for (int k = 1; k <= 8; k++)
            lookup(VPN_W'((k << 8) | 1), 0, K_FILL, 20'h70000 | PPN_W'(k), 1, 1, 0, "R4");
        lookup(20'h00020, 0, K_FILL, 20'h5A5A0, 1, 1, 0, "R4");
        lookup(20'h00101, 0, K_VIC,  20'h70001, 1, 1, 0, "R4");
        lookup(20'h00010, 0, K_VIC,  20'h44440, 0, 1, 0, "R4");
        // Full flush clears every mode
        command(1, 0, 0, 20'h0, 0);
        lookup(20'h00801, 0, K_FILL, 20'h12340, 1, 1, 0, "R5");
        lookup(20'h00020, 1, K_FILL, 20'h23450, 1, 0, 0, "R5");
        // Refill offered in a command cycle is ignored
        lookup(20'h00030, 0, K_FILL, 20'h66660, 1, 1, 0, "R9", 1);
        lookup(20'h00030, 0, K_PRI,  20'h66660, 1, 1, 0, "R9");

        repeat (3) @(negedge clk);
        chk("R3", "outstanding expected responses", expq.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R3 watchdog expired: act=%0d exp=done", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule